// File: doc/BRIEF.md
# Residue-Leg Multiplexer Function Generator

This block is a configurable logic cell that can produce any Boolean function of `NVARS` input variables. It uses one selector with `NVARS-1` select lines. The upper `NVARS-1` variables form the index of a data leg. Each leg carries a small residue function of the one remaining variable (the lowest input bit), so the cell needs only `2^(NVARS-1)` legs, not a full `2^NVARS`-entry truth table.

Every leg is programmed with a 2-bit code. The code picks constant zero, constant one, the free variable, or the inverse of the free variable. The codes sit in a configuration register that loads on a clock edge while a load strobe is high.

The selector is a cascade of smaller selectors. The lower select bits steer two half-size selectors in parallel, and the top select bit chooses between their outputs. From the variables to the output the path is purely combinational, so the cell acts as a lookup element whose contents can be reprogrammed.

Top module: `residue_mux_cell`

## Requirements
- R1: After reset the stored configuration is all zeros, so `fn_out` is 0 for every value of `vars_in` until a load takes place.
- R2: When the selected leg holds code `2'b00`, `fn_out` is 0 whatever the value of `vars_in[0]`.
- R3: When the selected leg holds code `2'b01`, `fn_out` is 1 whatever the value of `vars_in[0]`.
- R4: When the selected leg holds code `2'b10`, `fn_out` equals `vars_in[0]`.
- R5: When the selected leg holds code `2'b11`, `fn_out` equals the inverse of `vars_in[0]`.
- R6: The selected leg index is `vars_in[NVARS-1:1]`, with `vars_in[NVARS-1]` as the most significant bit. Leg i is coded by bits `[2i+1:2i]` of the configuration, so leg 0 sits in the least significant bits.
- R7: The configuration is captured from `cfg_in` on a rising clock edge while `cfg_load` is 1. Before that edge `fn_out` still follows the old configuration, and from that edge on it follows the new one.
- R8: While `cfg_load` is 0, changes on `cfg_in` have no effect on `fn_out`.
- R9: `fn_out` follows a change of `vars_in` within the same clock cycle, with no clock edge in between.
- R10: With `NVARS`=3 and legs 3..0 coded `01`, `00`, `11`, `11` (`cfg_in` = 8'h4F), `fn_out` is 1 exactly for input values 0, 2, 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration register |
| rst_n | input | 1 | Active-low asynchronous reset; clears the configuration |
| cfg_load | input | 1 | Load strobe for the configuration register |
| cfg_in | input | 2*2^(NVARS-1) | New leg codes, leg 0 in the lowest two bits |
| vars_in | input | NVARS | Function variables; bit 0 is the free variable, the upper bits select the leg |
| fn_out | output | 1 | Function value |

## Verification
A wrong stored leg code shows up on `fn_out` only when `vars_in` selects that leg, and only for the value of the free variable on which the wrong code differs from the right one. Sweeping every input pattern after each load therefore exposes it within one pass of `2^NVARS` cycles. A mis-wired stage of the cascade makes one leg appear under another leg's index. The one-hot leg patterns catch this at the first index where the two disagree. A faulty load strobe shows in the cycle right after the intended edge: either the old function persists, or a held-off `cfg_in` leaks through.

// File: rtl/rmux_pkg.sv
package rmux_pkg;

  // Residue code held per data leg
  typedef enum logic [1:0] {
    LEG_ZERO = 2'b00,
    LEG_ONE  = 2'b01,
    LEG_VAR  = 2'b10,
    LEG_INV  = 2'b11
  } leg_code_t;

  // Value a leg presents given its code and the free variable
  function automatic logic leg_value(input logic [1:0] code, input logic d);
    case (leg_code_t'(code))
      LEG_ZERO: leg_value = 1'b0;
      LEG_ONE:  leg_value = 1'b1;
      LEG_VAR:  leg_value = d;
      default:  leg_value = ~d;
    endcase
  endfunction

endpackage

// File: rtl/rmux_cfg_reg.sv
module rmux_cfg_reg #(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CFG_W-1:0] cfg_d,
  output logic [CFG_W-1:0] cfg_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfg_q <= '0;
    else if (load) cfg_q <= cfg_d;
  end

  // R7: a strobed edge captures the presented codes
  a_r7_load_capture: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cfg_q == $past(cfg_d));

  // R8: without the strobe the stored codes stay put
  a_r8_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cfg_q));

endmodule

// File: rtl/rmux_leg_bank.sv
module rmux_leg_bank
  import rmux_pkg::*;
#(
  parameter int NLEGS = 4,
  localparam int CFG_W = 2 * NLEGS
) (
  input  logic [CFG_W-1:0] cfg,
  input  logic             d,
  output logic [NLEGS-1:0] leg_val
);

  for (genvar i = 0; i < NLEGS; i++) begin : g_leg
    assign leg_val[i] = leg_value(cfg[2*i +: 2], d);
  end

endmodule

// File: rtl/rmux_cascade.sv
module rmux_cascade #(
  parameter int SEL_W = 2,
  localparam int NIN = 2 ** SEL_W
) (
  input  logic [NIN-1:0]   legs,
  input  logic [SEL_W-1:0] sel,
  output logic             y
);

  if (SEL_W == 1) begin : g_leaf
    assign y = sel[0] ? legs[1] : legs[0];
  end else begin : g_split
    localparam int HALF = NIN / 2;
    logic [HALF-1:0]  lo_legs, hi_legs;
    logic [SEL_W-2:0] low_sel;
    logic             stage_lo, stage_hi;

    assign lo_legs = legs[HALF-1:0];
    assign hi_legs = legs[NIN-1:HALF];
    assign low_sel = sel[SEL_W-2:0];

    // first stage: both halves steered by the lower select bits at once
    assign stage_lo = lo_legs[low_sel];
    assign stage_hi = hi_legs[low_sel];

    // second stage: the top select bit picks a half
    assign y = sel[SEL_W-1] ? stage_hi : stage_lo;
  end

endmodule

// File: rtl/residue_mux_cell.sv
module residue_mux_cell #(
  parameter int NVARS = 3,          // supported range 2..6
  localparam int SEL_W = NVARS - 1,
  localparam int NLEGS = 2 ** SEL_W,
  localparam int CFG_W = 2 * NLEGS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic [CFG_W-1:0] cfg_in,
  input  logic [NVARS-1:0] vars_in,
  output logic             fn_out
);

  logic [CFG_W-1:0] cfg_q;
  logic [NLEGS-1:0] leg_val;
  logic [SEL_W-1:0] sel_idx;
  logic             free_var;
  logic [1:0]       sel_code;   // code of the leg being observed, for assertions

  assign sel_idx  = vars_in[NVARS-1:1];
  assign free_var = vars_in[0];
  assign sel_code = cfg_q[{sel_idx, 1'b0} +: 2];

  rmux_cfg_reg #(.CFG_W(CFG_W)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cfg_load),
    .cfg_d (cfg_in),
    .cfg_q (cfg_q)
  );

  rmux_leg_bank #(.NLEGS(NLEGS)) u_legs (
    .cfg     (cfg_q),
    .d       (free_var),
    .leg_val (leg_val)
  );

  rmux_cascade #(.SEL_W(SEL_W)) u_sel (
    .legs (leg_val),
    .sel  (sel_idx),
    .y    (fn_out)
  );

  // R2
  a_r2_zero_leg: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_code == 2'b00) |-> (fn_out == 1'b0));
  // R3
  a_r3_one_leg: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_code == 2'b01) |-> (fn_out == 1'b1));
  // R4
  a_r4_pass_leg: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_code == 2'b10) |-> (fn_out == free_var));
  // R5
  a_r5_inv_leg: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_code == 2'b11) |-> (fn_out == !free_var));

endmodule

// File: tb/sim_residue_mux_cell.sv
`timescale 1ns/1ps
module sim_residue_mux_cell;

  localparam int NV    = 3;
  localparam int NL    = 2 ** (NV - 1);
  localparam int CW    = 2 * NL;
  localparam int NROWS = 2 ** NV;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_load = 1'b0;
  logic [CW-1:0] cfg_in = '0;
  logic [NV-1:0] vars_in = '0;
  logic          fn_out;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  typedef struct {
    logic          exp;
    logic [NV-1:0] v;
    string         tag;
  } item_t;

  item_t sb[$];

  always #4 clk = ~clk;

  residue_mux_cell #(.NVARS(NV)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
    .cfg_in(cfg_in), .vars_in(vars_in), .fn_out(fn_out)
  );

  // Expand leg codes into a full truth table, two rows per leg
  function automatic logic [NROWS-1:0] table_of(input logic [CW-1:0] c);
    logic [NROWS-1:0] t;
    t = '0;
    for (int l = 0; l < NL; l++) begin
      case (c[2*l +: 2])
        2'b00: t[2*l +: 2] = 2'b00;
        2'b01: t[2*l +: 2] = 2'b11;
        2'b10: t[2*l +: 2] = 2'b10;
        default: t[2*l +: 2] = 2'b01;
      endcase
    end
    return t;
  endfunction

  task automatic drive(input logic [NV-1:0] v, input logic [CW-1:0] model, input string tag);
    item_t it;
    @(negedge clk);
    vars_in = v;
    it.exp = table_of(model)[v];
    it.v = v;
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic sweep(input logic [CW-1:0] model, input string tag);
    for (int r = 0; r < NROWS; r++) drive(r[NV-1:0], model, tag);
  endtask

  task automatic load(input logic [CW-1:0] c);
    @(negedge clk);
    cfg_in = c;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  // Monitor: sample 2 ns after each falling edge, away from the rising edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        total++;
        if (fn_out !== it.exp) begin
          bad++;
          $display("FAIL %s vars=%0d actual=%b expected=%b", it.tag, it.v, fn_out, it.exp);
        end
      end
    end
  end

  initial begin
    logic [CW-1:0] cur;
    // R1: load strobe low, garbage on cfg_in, reset state must give all zeros
    cfg_in = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    sweep('0, "R1 reset");

    // R2..R5: every leg the same code
    load({NL{2'b00}}); sweep({NL{2'b00}}, "R2 zero");
    load({NL{2'b01}}); sweep({NL{2'b01}}, "R3 one");
    load({NL{2'b10}}); sweep({NL{2'b10}}, "R4 pass");
    load({NL{2'b11}}); sweep({NL{2'b11}}, "R5 invert");

    // R6: one leg at constant one, the rest zero
    for (int k = 0; k < NL; k++) begin
      logic [CW-1:0] c;
      c = '0;
      c[2*k +: 2] = 2'b01;
      load(c);
      sweep(c, "R6 leg index");
    end

    // R10: worked example, minterms 0,2,6,7
    load(8'h4F);
    sweep(8'h4F, "R10 example");
    cur = 8'h4F;

    // R7: before the strobed edge the old function, after it the new one
    for (int n = 0; n < 6; n++) begin
      logic [CW-1:0] nc;
      item_t it;
      logic [NV-1:0] v;
      nc = CW'($urandom);
      v = NV'($urandom);
      @(negedge clk);
      cfg_in = nc; cfg_load = 1'b1; vars_in = v;
      it.exp = table_of(cur)[v]; it.v = v; it.tag = "R7 before edge";
      sb.push_back(it);
      @(negedge clk);
      cfg_load = 1'b0;
      it.exp = table_of(nc)[v]; it.v = v; it.tag = "R7 after edge";
      sb.push_back(it);
      cur = nc;
    end

    // Random configurations, full sweep; then R8 with cfg_in changed, strobe low
    for (int n = 0; n < 40; n++) begin
      logic [CW-1:0] c;
      c = CW'($urandom);
      load(c);
      sweep(c, "R6 random sweep");
      @(negedge clk);
      cfg_in = ~c;
      sweep(c, "R8 held config");
    end

    // R9: input changes with no clock edge between them
    load(8'h4F);
    @(negedge clk);
    vars_in = 3'd0;
    #1;
    vars_in = 3'd1;
    #0.5;
    begin
      item_t it;
      it.exp = 1'b0; it.v = 3'd1; it.tag = "R9 same cycle";
      sb.push_back(it);
    end

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule